// File: doc/BRIEF.md
# Reciprocal-Based 24-bit Modular Multiplier

This block forms products modulo a prime of at most 24 bits without a divider. The quotient of the product by the modulus is estimated by multiplying the upper 32 bits of the 48-bit product by a precomputed fixed-point reciprocal and truncating the result. The block then subtracts the low 32 bits of quotient × modulus from the low 32 bits of the product. The result of a multiply is a redundant residue. It is congruent to the product but is not corrected into the canonical range, so a chain of transform butterflies can defer that final correction.

A second mode maps a signed 32-bit redundant value to its canonical residue in [0, m−1]. It first adds a bias of 100·m so that the operand is positive. It then estimates the quotient from the reciprocal, subtracts quotient × modulus and adds m once if the difference is negative. Both modes share one three-stage pipeline. The pipeline accepts one operation per cycle, and the modulus and reciprocal travel with each operation.

Top module: `modmul24_red`

## Requirements
- R1: While reset is low and for the first three cycles after it is released, `out_valid` is low.
- R2: Every operation accepted with `in_valid` high produces exactly one result with `out_valid` high three clock edges later, in issue order. Operations may be issued on consecutive cycles.
- R3: With `op_mode` = 0 (multiply), `result` is congruent to `op_a`·`op_b` modulo `modulus`. This holds for any 24-bit operands, including operands not below the modulus. It requires `modulus` to be odd and in (2^17, 2^24), and `recip` = floor(2^56 / `modulus`).
- R4: A multiply result, read as a signed 32-bit value, lies in [0, 2·`modulus` + 2^16).
- R5: With `op_mode` = 1 (reduce), `result` equals the canonical residue of the signed input `red_in` in [0, `modulus`−1], for any |`red_in`| ≤ 100·`modulus`.
- R6: Reduce is exact at the ends of its input range, at −100·`modulus` and +100·`modulus`, and around zero and multiples of the modulus.
- R7: Reducing a multiply result yields exactly (`op_a`·`op_b`) mod `modulus`.
- R8: Back-to-back operations may change mode and modulus on every cycle without affecting one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation is presented this cycle |
| op_mode | input | 1 | 0 = multiply, 1 = canonical reduce |
| op_a | input | 24 | First multiply operand |
| op_b | input | 24 | Second multiply operand |
| red_in | input | 32 | Signed redundant value for reduce |
| modulus | input | 24 | Odd modulus, 2^17 < m < 2^24 |
| recip | input | 40 | floor(2^56 / modulus) |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Signed result (redundant for multiply, canonical for reduce) |

## Verification
A wrong quotient estimate in either mode shows at the ports three cycles after the operation is issued. Off by one, the result falls outside its stated range. Off by more, or with a wrong shift, the result stops being congruent to the product. A reduce with the final correction broken gives a negative or too-large result only for inputs whose estimate rounds up. For this reason every modulus sees inputs across the whole ±100·m window and at multiples of m. If per-operation state is crossed between pipeline stages, operations that alternate mode and modulus on consecutive cycles produce wrong values. The issue-to-result cycle count exposes any bubble or slip in the valid pipeline.

// File: rtl/mm_pkg.sv
// Shared types for the reciprocal modular multiplier.
package mm_pkg;
    // Operation selector carried down the pipeline.
    typedef enum logic {
        MM_MUL = 1'b0,
        MM_RED = 1'b1
    } mm_mode_e;
endpackage

// File: rtl/mm_prep.sv
// Stage 1: forms the full product (multiply mode) or the biased value
// (reduce mode) and picks the word whose quotient by m is to be estimated.
// Assumes |x| <= BIAS_K*m so that the biased value stays inside ACC_W bits.
module mm_prep
    import mm_pkg::*;
#(
    parameter int OP_W   = 24,
    parameter int ACC_W  = 32,
    parameter int RCP_W  = 40,
    parameter int BIAS_K = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  mm_mode_e          mode_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic [ACC_W-1:0]  x_i,
    input  logic [OP_W-1:0]   m_i,
    input  logic [RCP_W-1:0]  rcp_i,
    output logic              v_o,
    output mm_mode_e          mode_o,
    output logic [ACC_W-1:0]  base_o,
    output logic [ACC_W-1:0]  top_o,
    output logic [OP_W-1:0]   m_o,
    output logic [RCP_W-1:0]  rcp_o
);
    localparam int PROD_W  = 2 * OP_W;
    localparam int TOP_LSB = PROD_W - ACC_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  biased;
    logic [ACC_W-1:0]  base_n;
    logic [ACC_W-1:0]  top_n;

    // Product and biased operand, then the per-mode word selection.
    always_comb begin
        prod   = PROD_W'(a_i) * PROD_W'(b_i);
        biased = x_i + ACC_W'(BIAS_K) * ACC_W'(m_i);
        if (mode_i == MM_MUL) begin
            base_n = prod[ACC_W-1:0];
            top_n  = prod[PROD_W-1:TOP_LSB];
        end else begin
            base_n = biased;
            top_n  = biased;
        end
    end

    // Valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_o <= 1'b0;
        else        v_o <= v_i;
    end

    // Datapath registers, loaded on every accepted operation.
    always_ff @(posedge clk) begin
        if (v_i) begin
            mode_o <= mode_i;
            base_o <= base_n;
            top_o  <= top_n;
            m_o    <= m_i;
            rcp_o  <= rcp_i;
        end
    end
endmodule

// File: rtl/mm_qest.sv
// Stage 2: quotient estimate by reciprocal multiplication and truncation.
// Multiply mode: floor(top*rcp / 2^MUL_SH), never above the true quotient.
// Reduce mode: floor(top*rcp / 2^RSH) + 1, which is the true quotient or one more.
// Assumes rcp = floor(2^RSH / m).
module mm_qest
    import mm_pkg::*;
#(
    parameter int OP_W   = 24,
    parameter int ACC_W  = 32,
    parameter int RCP_W  = 40,
    parameter int RSH    = 56,
    parameter int MUL_SH = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  mm_mode_e          mode_i,
    input  logic [ACC_W-1:0]  base_i,
    input  logic [ACC_W-1:0]  top_i,
    input  logic [OP_W-1:0]   m_i,
    input  logic [RCP_W-1:0]  rcp_i,
    output logic              v_o,
    output mm_mode_e          mode_o,
    output logic [ACC_W-1:0]  base_o,
    output logic [OP_W-1:0]   m_o,
    output logic [ACC_W-1:0]  q_o
);
    localparam int PRD_W = ACC_W + RCP_W;

    logic [PRD_W-1:0] prd;
    logic [PRD_W-1:0] sh_mul;
    logic [PRD_W-1:0] sh_red;
    logic [ACC_W-1:0] q_n;

    // Scaled product and the two truncations, with the reduce round-up.
    always_comb begin
        prd    = PRD_W'(top_i) * PRD_W'(rcp_i);
        sh_mul = prd >> MUL_SH;
        sh_red = prd >> RSH;
        if (mode_i == MM_MUL) q_n = sh_mul[ACC_W-1:0];
        else                  q_n = sh_red[ACC_W-1:0] + ACC_W'(1);
    end

    // Valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_o <= 1'b0;
        else        v_o <= v_i;
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (v_i) begin
            mode_o <= mode_i;
            base_o <= base_i;
            m_o    <= m_i;
            q_o    <= q_n;
        end
    end
endmodule

// File: rtl/mm_fix.sv
// Stage 3: subtracts the low ACC_W bits of q*m from the base word. In
// reduce mode it adds m once when that difference is negative.
// Assumes the true difference fits in a signed ACC_W word.
module mm_fix
    import mm_pkg::*;
#(
    parameter int OP_W  = 24,
    parameter int ACC_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_i,
    input  mm_mode_e                 mode_i,
    input  logic [ACC_W-1:0]         base_i,
    input  logic [OP_W-1:0]          m_i,
    input  logic [ACC_W-1:0]         q_i,
    output logic                     v_o,
    output logic signed [ACC_W-1:0]  res_o
);
    logic [ACC_W-1:0] qm;
    logic [ACC_W-1:0] diff;
    logic [ACC_W-1:0] res_n;

    // Low-word subtraction and the single conditional correction.
    always_comb begin
        qm   = q_i * ACC_W'(m_i);
        diff = base_i - qm;
        if (mode_i == MM_RED && diff[ACC_W-1]) res_n = diff + ACC_W'(m_i);
        else                                   res_n = diff;
    end

    // Valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_o <= 1'b0;
        else        v_o <= v_i;
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (v_i) res_o <= res_n;
    end
endmodule

// File: rtl/modmul24_red.sv
// Top: three-stage modular multiply / canonical reduce pipeline.
// Assumes an odd modulus in (2^17, 2^24) with recip = floor(2^RSH / modulus),
// and |red_in| <= BIAS_K*modulus in reduce mode. Latency 3, one op per cycle.
module modmul24_red
    import mm_pkg::*;
#(
    parameter int OP_W   = 24,
    parameter int ACC_W  = 32,
    parameter int RCP_W  = 40,
    parameter int RSH    = 56,
    parameter int BIAS_K = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     op_mode,
    input  logic [OP_W-1:0]          op_a,
    input  logic [OP_W-1:0]          op_b,
    input  logic signed [ACC_W-1:0]  red_in,
    input  logic [OP_W-1:0]          modulus,
    input  logic [RCP_W-1:0]         recip,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  result
);
    localparam int TOP_LSB = 2 * OP_W - ACC_W;
    localparam int MUL_SH  = RSH - TOP_LSB;

    mm_mode_e          mode_in;
    logic              v1, v2;
    mm_mode_e          mode1, mode2;
    logic [ACC_W-1:0]  base1, base2, top1, q2;
    logic [OP_W-1:0]   m1, m2;
    logic [RCP_W-1:0]  rcp1;

    // Map the raw mode pin onto the enumerated type.
    always_comb mode_in = op_mode ? MM_RED : MM_MUL;

    mm_prep #(.OP_W(OP_W), .ACC_W(ACC_W), .RCP_W(RCP_W), .BIAS_K(BIAS_K)) u_prep (
        .clk(clk), .rst_n(rst_n), .v_i(in_valid), .mode_i(mode_in),
        .a_i(op_a), .b_i(op_b), .x_i(red_in), .m_i(modulus), .rcp_i(recip),
        .v_o(v1), .mode_o(mode1), .base_o(base1), .top_o(top1), .m_o(m1), .rcp_o(rcp1)
    );

    mm_qest #(.OP_W(OP_W), .ACC_W(ACC_W), .RCP_W(RCP_W), .RSH(RSH), .MUL_SH(MUL_SH)) u_qest (
        .clk(clk), .rst_n(rst_n), .v_i(v1), .mode_i(mode1), .base_i(base1),
        .top_i(top1), .m_i(m1), .rcp_i(rcp1),
        .v_o(v2), .mode_o(mode2), .base_o(base2), .m_o(m2), .q_o(q2)
    );

    mm_fix #(.OP_W(OP_W), .ACC_W(ACC_W)) u_fix (
        .clk(clk), .rst_n(rst_n), .v_i(v2), .mode_i(mode2), .base_i(base2),
        .m_i(m2), .q_i(q2), .v_o(out_valid), .res_o(result)
    );
endmodule

// File: rtl/mm_modmul_chk.sv
// Checker for modmul24_red: latency, reset quiet period, result ranges
// and congruence. Defaults must match the top's parameters.
module mm_modmul_chk #(
    parameter int OP_W  = 24,
    parameter int ACC_W = 32,
    parameter int RCP_W = 40
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     op_mode,
    input logic [OP_W-1:0]          op_a,
    input logic [OP_W-1:0]          op_b,
    input logic signed [ACC_W-1:0]  red_in,
    input logic [OP_W-1:0]          modulus,
    input logic [RCP_W-1:0]         recip,
    input logic                     out_valid,
    input logic signed [ACC_W-1:0]  result
);
    logic [1:0] cyc;

    // Edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= 2'd0;
        else if (cyc != 3) cyc <= cyc + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd3) |-> !out_valid); // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_MUL_CONGRUENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && !$past(op_mode, 3)) |->
        (((longint'(result) - longint'($past(op_a, 3)) * longint'($past(op_b, 3)))
          % longint'($past(modulus, 3))) == 0)); // R3

    AST_MUL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && !$past(op_mode, 3)) |->
        (longint'(result) >= 0 &&
         longint'(result) < 2 * longint'($past(modulus, 3)) + 65536)); // R4

    AST_RED_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && $past(op_mode, 3)) |->
        (longint'(result) >= 0 && longint'(result) < longint'($past(modulus, 3)))); // R5

    AST_RED_CONGRUENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && $past(op_mode, 3)) |->
        (((longint'(result) - longint'($past(red_in, 3)))
          % longint'($past(modulus, 3))) == 0)); // R5
endmodule

bind modmul24_red mm_modmul_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
    .op_a(op_a), .op_b(op_b), .red_in(red_in), .modulus(modulus),
    .recip(recip), .out_valid(out_valid), .result(result)
);

// File: tb/modmul24_red_tb.sv
`timescale 1ns/1ps
module modmul24_red_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               op_mode = 1'b0;
    logic [23:0]        op_a = '0;
    logic [23:0]        op_b = '0;
    logic signed [31:0] red_in = '0;
    logic [23:0]        modulus = 24'd786433;
    logic [39:0]        recip = '0;
    logic               out_valid;
    logic signed [31:0] result;

    typedef struct {
        bit     mode;
        longint a, b, x, m, expv;
        int     icyc;
    } item_t;

    typedef struct { longint a, b, m, r; } chain_t;

    item_t  exp_q[$];
    chain_t chain_q[$];
    int     n_checks = 0;
    int     n_fail = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    longint primes[4] = '{786433, 5767169, 7340033, 10223617};

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    modmul24_red u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
        .op_a(op_a), .op_b(op_b), .red_in(red_in), .modulus(modulus),
        .recip(recip), .out_valid(out_valid), .result(result)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic longint canon(input longint x, input longint m);
        return ((x % m) + m) % m;
    endfunction

    // Driver: presents one operation in the next cycle and records its expectation.
    task automatic issue(input bit mode, input longint a, input longint b,
                         input longint x, input longint m, input longint expv);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op_mode  = mode;
        op_a     = 24'(a);
        op_b     = 24'(b);
        red_in   = 32'(x);
        modulus  = 24'(m);
        recip    = 40'((64'd1 << 56) / 64'(m));
        it.mode = mode; it.a = a; it.b = b; it.x = x; it.m = m;
        it.expv = expv; it.icyc = cyc;
        exp_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_mul(input longint a, input longint b, input longint m);
        issue(1'b0, a, b, 0, m, 0);
    endtask

    task automatic do_red(input longint x, input longint m);
        issue(1'b1, 0, 0, x, m, canon(x, m));
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", longint'(result), 0);
            end else begin
                item_t  it;
                chain_t c;
                longint r;
                it = exp_q.pop_front();
                r  = longint'(result);
                check(cyc - it.icyc == 3, "R2 latency", cyc - it.icyc, 3);
                if (!it.mode) begin
                    check(((r - it.a * it.b) % it.m) == 0, "R3 congruence", r, (it.a * it.b) % it.m);
                    check(r >= 0 && r < 2 * it.m + 65536, "R4 range", r, 2 * it.m + 65536);
                    c.a = it.a; c.b = it.b; c.m = it.m; c.r = r;
                    chain_q.push_back(c);
                end else begin
                    check(r == it.expv, "R5 reduce", r, it.expv);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: quiet during reset and just after release.
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 after reset", longint'(out_valid), 0);
        end

        // R3/R4: corner and random multiplies, back to back per modulus.
        foreach (primes[p]) begin
            longint m;
            m = primes[p];
            do_mul(m - 1, m - 1, m);
            do_mul(0, 12345, m);
            do_mul(24'hFFFFFF, 24'hFFFFFF, m);
            do_mul(1, m - 1, m);
            do_mul(m + 5, 24'hFFFFFF, m);
            for (int i = 0; i < 15; i++)
                do_mul(longint'($urandom & 32'hFFFFFF), longint'($urandom) % m, m);
        end
        idle();

        // R5/R6: reduce at range ends, near zero and at multiples of m.
        foreach (primes[p]) begin
            longint m;
            m = primes[p];
            do_red(-100 * m, m);
            do_red(100 * m, m);
            do_red(0, m);
            do_red(-1, m);
            do_red(m - 1, m);
            do_red(m, m);
            do_red(-m, m);
            do_red(2 * m - 1, m);
            do_red(-100 * m + 1, m);
            do_red(100 * m - 1, m);
            for (int i = 0; i < 10; i++)
                do_red(longint'($urandom) % (200 * m + 1) - 100 * m, m);
        end
        idle();

        // R8: mode and modulus change on every cycle.
        for (int i = 0; i < 40; i++) begin
            longint m;
            m = primes[$urandom % 4];
            if (i % 2 == 0) do_mul(longint'($urandom & 32'hFFFFFF), longint'($urandom & 32'hFFFFFF), m);
            else            do_red(longint'($urandom) % (200 * m + 1) - 100 * m, m);
        end
        idle();
        while (exp_q.size() != 0) @(negedge clk);

        // R7: reduce every multiply result to the exact product residue.
        while (chain_q.size() != 0) begin
            chain_t c;
            c = chain_q.pop_front();
            issue(1'b1, 0, 0, c.r, c.m, (c.a * c.b) % c.m); // R7
        end
        idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule